// File: doc/BRIEF.md
# Self-Aligned Dual-Bank Instruction Fetch

This block hands a pipeline front end four consecutive fixed-width instructions every cycle, wherever the fetch target lands inside a storage line. A line holds four 32-bit instruction slots. Lines with an even line number live in one bank and lines with an odd line number live in the other. Two neighbouring lines are therefore always in opposite banks, so the block can read both in the same cycle without a port conflict. It takes the line holding the target and the line after it, joins them into an eight-slot window, and rotates that window so the target instruction comes out in output slot 0.

The fetch address is given in instruction words, not bytes. Its low two bits pick the starting slot, bit 2 tells which bank holds the first line, and the upper bits name the line pair. A line write port fills the banks one 128-bit line at a time. The bank reads take one clock, so results appear in the cycle after the request. A two-state controller tracks this. ST_IDLE means no result is on the output. ST_SERVE means a result is on the output. The transitions are: IDLE to SERVE on a request, SERVE to SERVE on a back-to-back request, SERVE to IDLE when no request arrives, and IDLE to IDLE while no request arrives.

Top module: `selfalign_fetch`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `instr_valid` is all zeros.
- R2: One cycle after `fetch_req` is high with word address A, all four bits of `instr_valid` are 1. Output slot k (bits [32k+31:32k] of `instr_out`) holds the instruction at word address (A+k) modulo the storage size.
- R3: A start slot of 1, 2 or 3 (A[1:0] nonzero) still yields four valid instructions. The later slots are taken from the following line.
- R4: A start line with an odd line number (A[2] = 1) is read from the odd bank. Its successor is read from the even bank at the next pair index, and the results are correct.
- R5: A request in the last line wraps around, so its trailing instructions come from line 0.
- R6: A write with `wr_en` high stores `wr_data` as line `wr_line`, with slot k in bits [32k+31:32k]. Any later read of that line returns the new data.
- R7: A request in the same cycle as a write to a line it covers returns the data the line held before the write.
- R8: In a cycle after `fetch_req` was low, `instr_valid` is all zeros and `instr_out` keeps its previous value, even if a line write took place.
- R9: Requests on consecutive cycles each produce their own correct result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request this cycle |
| fetch_addr | input | 8 | Word address of the first instruction |
| wr_en | input | 1 | Line write enable |
| wr_line | input | 6 | Line number to write |
| wr_data | input | 128 | Line contents, slot k in bits [32k+31:32k] |
| instr_out | output | 128 | Four instructions, start instruction in bits [31:0] |
| instr_valid | output | 4 | Per-slot valid flags |

## Verification
The bench sweeps every start slot in both even and odd lines. A design that indexed the even bank without the carry would return the wrong successor line for odd starts. A rotation off by one slot would shift every instruction. It also fetches from the last line, where an index that did not wrap would read past the end of storage instead of line 0. Writes are made in the same cycle as a read of the same line, to catch a design that forwards the new data. A write is also made during an idle cycle, to catch a design whose held output is disturbed by a write or by a read it should not have made.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int DEF_INSTR_W = 32;
    localparam int DEF_SLOTS   = 4;
    localparam int DEF_LINES   = 64;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } fetch_state_e;
endpackage

// File: rtl/fetch_bank.sv
module fetch_bank #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data
);
    logic [WIDTH-1:0] store [DEPTH];

    // Read and write both use nonblocking updates: a same-index read sees old contents.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= store[rd_idx];
        end
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/fetch_index_gen.sv
module fetch_index_gen #(
    parameter int LINE_AW = 6,
    localparam int BANK_AW = LINE_AW - 1
) (
    input  logic [LINE_AW-1:0] line,
    output logic               first_odd,
    output logic [BANK_AW-1:0] even_idx,
    output logic [BANK_AW-1:0] odd_idx
);
    logic [BANK_AW-1:0] pair;

    always_comb begin
        pair      = line[LINE_AW-1:1];
        first_odd = line[0];
        odd_idx   = pair;
        // An odd first line is followed by the even line of the next pair; wraps at the top.
        even_idx  = pair + BANK_AW'(line[0]);
    end
endmodule

// File: rtl/fetch_rotate.sv
module fetch_rotate #(
    parameter int INSTR_W = 32,
    parameter int SLOTS   = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int LINE_W = INSTR_W * SLOTS
) (
    input  logic [2*LINE_W-1:0] window,
    input  logic [SLOT_W-1:0]   start,
    output logic [LINE_W-1:0]   picked
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [SLOT_W:0] src;
        assign src = {1'b0, start} + (SLOT_W+1)'(k);
        assign picked[k*INSTR_W +: INSTR_W] = window[src*INSTR_W +: INSTR_W];
    end
endmodule

// File: rtl/selfalign_fetch.sv
module selfalign_fetch
    import fetch_pkg::*;
#(
    parameter int INSTR_W = DEF_INSTR_W,
    parameter int SLOTS   = DEF_SLOTS,
    parameter int LINES   = DEF_LINES,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int LINE_AW = $clog2(LINES),
    localparam int LINE_W  = INSTR_W * SLOTS,
    localparam int WADDR_W = LINE_AW + SLOT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_req,
    input  logic [WADDR_W-1:0] fetch_addr,
    input  logic               wr_en,
    input  logic [LINE_AW-1:0] wr_line,
    input  logic [LINE_W-1:0]  wr_data,
    output logic [LINE_W-1:0]  instr_out,
    output logic [SLOTS-1:0]   instr_valid
);
    localparam int BANK_AW    = LINE_AW - 1;
    localparam int BANK_DEPTH = LINES / 2;

    fetch_state_e state_q, state_d;

    logic               first_odd, first_odd_q;
    logic [BANK_AW-1:0] even_idx, odd_idx;
    logic [SLOT_W-1:0]  slot_q;
    logic [LINE_W-1:0]  bank_rd [2];
    logic [LINE_W-1:0]  line_lo, line_hi;

    fetch_index_gen #(.LINE_AW(LINE_AW)) u_idx (
        .line      (fetch_addr[WADDR_W-1:SLOT_W]),
        .first_odd (first_odd),
        .even_idx  (even_idx),
        .odd_idx   (odd_idx)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam bit IS_ODD = (b == 1);
        fetch_bank #(.DEPTH(BANK_DEPTH), .WIDTH(LINE_W)) u_bank (
            .clk     (clk),
            .rd_en   (fetch_req),
            .rd_idx  (IS_ODD ? odd_idx : even_idx),
            .rd_data (bank_rd[b]),
            .wr_en   (wr_en && (wr_line[0] == IS_ODD)),
            .wr_idx  (wr_line[LINE_AW-1:1]),
            .wr_data (wr_data)
        );
    end

    // Start slot and bank order are registered to line up with the read data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q      <= '0;
            first_odd_q <= 1'b0;
        end else if (fetch_req) begin
            slot_q      <= fetch_addr[SLOT_W-1:0];
            first_odd_q <= first_odd;
        end
    end

    always_comb begin
        line_lo = first_odd_q ? bank_rd[1] : bank_rd[0];
        line_hi = first_odd_q ? bank_rd[0] : bank_rd[1];
    end

    fetch_rotate #(.INSTR_W(INSTR_W), .SLOTS(SLOTS)) u_rot (
        .window (({line_hi, line_lo})),
        .start  (slot_q),
        .picked (instr_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = fetch_req ? ST_SERVE : ST_IDLE;
            ST_SERVE: state_d = fetch_req ? ST_SERVE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        instr_valid = (state_q == ST_SERVE) ? '1 : '0;
    end
endmodule

// File: rtl/fetch_checker.sv
module fetch_checker #(
    parameter int INSTR_W = 32,
    parameter int SLOTS   = 4,
    localparam int LINE_W = INSTR_W * SLOTS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic [LINE_W-1:0] instr_out,
    input logic [SLOTS-1:0]  instr_valid
);
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (instr_valid == '0));

    p_req_gives_four_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> (instr_valid == '1));

    p_all_or_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid == '0) || (instr_valid == '1));

    p_idle_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> (instr_valid == '0));

    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> $stable(instr_out));
endmodule

bind selfalign_fetch fetch_checker #(.INSTR_W(INSTR_W), .SLOTS(SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .instr_out   (instr_out),
    .instr_valid (instr_valid)
);

// File: tb/tb_selfalign_fetch.sv
module tb_selfalign_fetch;
    localparam int INSTR_W = 32;
    localparam int SLOTS   = 4;
    localparam int LINES   = 64;
    localparam int LINE_W  = INSTR_W * SLOTS;
    localparam int WORDS   = LINES * SLOTS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_req = 1'b0;
    logic [7:0]        fetch_addr = '0;
    logic              wr_en = 1'b0;
    logic [5:0]        wr_line = '0;
    logic [LINE_W-1:0] wr_data = '0;
    logic [LINE_W-1:0] instr_out;
    logic [SLOTS-1:0]  instr_valid;

    selfalign_fetch #(.INSTR_W(INSTR_W), .SLOTS(SLOTS), .LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .wr_en(wr_en), .wr_line(wr_line), .wr_data(wr_data),
        .instr_out(instr_out), .instr_valid(instr_valid)
    );

    always #4 clk = ~clk;

    logic [INSTR_W-1:0] model [WORDS];
    logic               exp_valid = 1'b0;
    logic               exp_known = 1'b0;
    logic [LINE_W-1:0]  exp_line  = '0;
    string              exp_tag   = "R1";
    int                 total = 0;
    int                 failed = 0;
    bit                 done = 1'b0;

    function automatic logic [INSTR_W-1:0] word_val(int w, int gen);
        return (32'(w) * 32'h9E37_79B1) ^ (32'(gen) << 24) ^ 32'h0000_5A5A;
    endfunction

    function automatic logic [LINE_W-1:0] line_val(int l, int gen);
        logic [LINE_W-1:0] v;
        for (int k = 0; k < SLOTS; k++) v[k*INSTR_W +: INSTR_W] = word_val(l*SLOTS + k, gen);
        return v;
    endfunction

    task automatic check_now();
        total++;
        if (instr_valid !== {SLOTS{exp_valid}}) begin
            failed++;
            $display("FAIL %s valid: got %b expected %b", exp_tag, instr_valid, {SLOTS{exp_valid}});
        end else if (exp_known && instr_out !== exp_line) begin
            failed++;
            $display("FAIL %s data: got %h expected %h", exp_tag, instr_out, exp_line);
        end
    endtask

    // Called at a falling edge: check the current output, then drive the next cycle.
    task automatic step(input logic req, input int addr, input logic we, input int line,
                        input logic [LINE_W-1:0] data, input string tag);
        check_now();
        fetch_req  = req;
        fetch_addr = 8'(addr);
        wr_en      = we;
        wr_line    = 6'(line);
        wr_data    = data;
        if (req) begin
            for (int k = 0; k < SLOTS; k++)
                exp_line[k*INSTR_W +: INSTR_W] = model[(addr + k) % WORDS];
            exp_valid = 1'b1;
            exp_known = 1'b1;
            exp_tag   = tag;
        end else begin
            exp_valid = 1'b0;
            exp_tag   = "R8";
        end
        if (we) begin
            for (int k = 0; k < SLOTS; k++)
                model[line*SLOTS + k] = data[k*INSTR_W +: INSTR_W];
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (instr_valid !== '0) begin
            failed++;
            $display("FAIL R1 reset valid: got %b expected 0000", instr_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        exp_tag = "R1";
        check_now();

        // Fill every line (R6), idle outputs checked each cycle
        for (int l = 0; l < LINES; l++) step(0, 0, 1, l, line_val(l, 1), "R6");

        // Aligned start in an even line (R2)
        step(1, 0, 0, 0, '0, "R2");
        // Mid-line starts in even line 2 (R3)
        for (int s = 1; s < SLOTS; s++) step(1, 8 + s, 0, 0, '0, "R3");
        // Odd first line, every slot (R4)
        for (int s = 0; s < SLOTS; s++) step(1, 4*3 + s, 0, 0, '0, "R4");
        // Last line wraps to line 0 (R5)
        for (int s = 0; s < SLOTS; s++) step(1, 4*63 + s, 0, 0, '0, "R5");
        // Idle with a write to the line just read: output must hold (R8)
        step(0, 0, 1, 63, line_val(63, 2), "R8");
        step(0, 0, 0, 0, '0, "R8");
        // New contents of line 63 visible (R6)
        step(1, 4*63 + 1, 0, 0, '0, "R6");
        // Same-cycle read and write of line 5 returns old data (R7), then new (R6)
        step(1, 4*5 + 1, 1, 5, line_val(5, 3), "R7");
        step(1, 4*5 + 1, 0, 0, '0, "R6");
        // Write line 0 while reading across the wrap into it (R7), then new (R5)
        step(1, 4*63 + 2, 1, 0, line_val(0, 4), "R7");
        step(1, 4*63 + 2, 0, 0, '0, "R5");
        // Write odd line 7, read from line 6 slot 3 into it (R6)
        step(0, 0, 1, 7, line_val(7, 5), "R6");
        step(1, 4*6 + 3, 0, 0, '0, "R6");
        // Back-to-back stream over scattered addresses (R9)
        for (int i = 0; i < 60; i++) step(1, (i*37 + 5) % WORDS, 0, 0, '0, "R9");
        step(0, 0, 0, 0, '0, "R8");
        step(0, 0, 0, 0, '0, "R8");
        check_now();

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            failed++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule